// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Writes

This block keeps the time of day (seconds, minutes, hours) and the calendar date (day, month, year offset and a leap-year flag) in two packed 32-bit words. Both words are reachable over a small register bus that also has a control word. A single-cycle `tick` pulse advances the time by one second. Carries ripple from seconds through minutes, hours, day and month into the year. Month lengths, including February in leap years, come from the stored leap flag.

A bus write to the time or date word does not take effect at once. The written value is held aside, and a busy flag for that word shows in the control word. After `COMMIT_CYCLES` clock cycles the held value replaces the live one in a single step. Until then the live value keeps counting. Software is expected to wait for all busy flags to clear, then write the time of day, then the date. Because the words can change between two reads, a consistent snapshot needs the usual read-twice-and-compare loop.

Top module: `cal_keeper`

## Requirements
- R1: After reset the time word reads 0, the date word reads day 1, month 1, year 0 with the leap flag clear (0x00000101), and the control word reads 0.
- R2: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. The date word holds day in bits 4:0, month (1..12) in bits 11:8, year offset from 1970 in bits 21:16 and the leap flag in bit 22. All other bits read 0, and written values are stored masked to these fields.
- R3: Bus address 1 selects the time word, address 2 the date word and address 0 the control word. A write to the time word sets control bit 8, and a write to the date word sets control bit 7, for exactly `COMMIT_CYCLES` cycles. Control bit 9 and every other control bit read 0. The new value appears on the edge where the busy bit clears, and the old value is read until then.
- R4: A write to the time or date word while that word's busy bit is set is ignored, and the first pending value is the one committed.
- R5: Each tick adds one second. Seconds roll over from 59 to 0 into minutes, minutes from 59 to 0 into hours, and hours from 23 to 0 into the day.
- R6: The day rolls over to 1 after the last day of the month. That is 28 in February, or 29 when the leap flag is set, 30 in April, June, September and November, and 31 in every other month.
- R7: The month rolls over from 12 to 1 into the year. On every year increment the leap flag becomes 1 exactly when (year offset + 1970) is divisible by 4.
- R8: The year offset wraps from 63 to 0 (2033 to 1970), and the leap flag is cleared.
- R9: Without a tick and without a commit, the time and date words hold their values.
- R10: Writes to the control word or to the unused address 3 change nothing, and address 3 reads 0.
- R11: On the edge where a word commits, the held value replaces it exactly and a coincident tick has no effect on it. A day carry out of a time word that is being replaced is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 time, 2 date, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address sampled on the previous edge |

## Verification
Ticks are applied at values just below each rollover point: 23:59:58, x:59:59, and month ends in 30-day, 31-day, February leap and February non-leap months. The year is also tried at 1971 (entering a leap year) and at 2033 (wrap). Together these separate a wrong carry chain, a wrong month-length table and a wrong leap recompute. Writes are probed cycle by cycle while the busy bit is set. Writes are also repeated during the busy window and coincide with a tick on the commit edge, which shows whether commit timing, dropping of the second write and priority of the commit over the tick and its carry are correct. A behavioural model is compared against the read data on every cycle, so a deviation is caught whenever the bus looks at the affected word.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int WORD_W = 32;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YR_W   = 6;

  // field positions seen by software
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HR_LSB   = 16;
  localparam int DAY_LSB  = 0;
  localparam int MON_LSB  = 8;
  localparam int YR_LSB   = 16;
  localparam int LEAP_BIT = 22;

  // control word busy flags
  localparam int BUSY_YMD_BIT = 7;
  localparam int BUSY_TOD_BIT = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TOD  = 2'd1;
  localparam logic [1:0] A_YMD  = 2'd2;

  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(23);
  localparam logic [MON_W-1:0] MON_TOP = MON_W'(12);

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } tod_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
  } ymd_t;

  localparam ymd_t YMD_RESET = '{leap: 1'b0, yr: '0, mon: MON_W'(1), day: DAY_W'(1)};

  function automatic logic [WORD_W-1:0] tod_to_word(input tod_t t);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEC_LSB +: SEC_W] = t.sc;
    w[MIN_LSB +: MIN_W] = t.mn;
    w[HR_LSB  +: HR_W]  = t.hr;
    return w;
  endfunction

  function automatic tod_t word_to_tod(input logic [WORD_W-1:0] w);
    tod_t t;
    t.sc = w[SEC_LSB +: SEC_W];
    t.mn = w[MIN_LSB +: MIN_W];
    t.hr = w[HR_LSB  +: HR_W];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] ymd_to_word(input ymd_t d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DAY_LSB +: DAY_W] = d.day;
    w[MON_LSB +: MON_W] = d.mon;
    w[YR_LSB  +: YR_W]  = d.yr;
    w[LEAP_BIT]         = d.leap;
    return w;
  endfunction

  function automatic ymd_t word_to_ymd(input logic [WORD_W-1:0] w);
    ymd_t d;
    d.day  = w[DAY_LSB +: DAY_W];
    d.mon  = w[MON_LSB +: MON_W];
    d.yr   = w[YR_LSB  +: YR_W];
    d.leap = w[LEAP_BIT];
    return d;
  endfunction

  function automatic logic [DAY_W-1:0] month_last(input logic [MON_W-1:0] m, input logic lp);
    case (m)
      MON_W'(2):                                    return lp ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DAY_W'(30);
      default:                                      return DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_commit_slot.sv
module cal_commit_slot #(
  parameter int W             = 17,
  parameter int COMMIT_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic         fire,
  output logic [W-1:0] held
);
  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      held  <= '0;
    end else if (take && cnt_q == '0) begin
      cnt_q <= CNT_LOAD;
      held  <= din;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cal_tod_chain.sv
module cal_tod_chain
  import cal_pkg::*;
(
  input  tod_t cur,
  input  logic step,
  output tod_t nxt,
  output logic day_carry
);
  always_comb begin
    nxt       = cur;
    day_carry = 1'b0;
    if (step) begin
      if (cur.sc >= SEC_TOP) begin
        nxt.sc = '0;
        if (cur.mn >= MIN_TOP) begin
          nxt.mn = '0;
          if (cur.hr >= HR_TOP) begin
            nxt.hr    = '0;
            day_carry = 1'b1;
          end else begin
            nxt.hr = cur.hr + 1'b1;
          end
        end else begin
          nxt.mn = cur.mn + 1'b1;
        end
      end else begin
        nxt.sc = cur.sc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_ymd_chain.sv
module cal_ymd_chain
  import cal_pkg::*;
(
  input  ymd_t cur,
  input  logic step,
  output ymd_t nxt
);
  logic [DAY_W-1:0] last_day;
  logic [YR_W-1:0]  yr_inc;

  assign last_day = month_last(cur.mon, cur.leap);
  assign yr_inc   = cur.yr + 1'b1;

  always_comb begin
    nxt = cur;
    if (step) begin
      if (cur.day >= last_day) begin
        nxt.day = DAY_W'(1);
        if (cur.mon >= MON_TOP) begin
          nxt.mon  = MON_W'(1);
          nxt.yr   = yr_inc;
          // base year 1970 is 2 mod 4
          nxt.leap = ((yr_inc[1:0] + 2'd2) == 2'd0);
        end else begin
          nxt.mon = cur.mon + 1'b1;
        end
      end else begin
        nxt.day = cur.day + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
  import cal_pkg::*;
#(
  parameter int COMMIT_CYCLES = 3,
  parameter int ADDR_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int TOD_W = $bits(tod_t);
  localparam int YMD_W = $bits(ymd_t);

  tod_t tod_q, tod_nxt, tod_held;
  ymd_t ymd_q, ymd_nxt, ymd_held;
  logic t_busy, t_fire, d_busy, d_fire;
  logic t_take, d_take, day_carry;
  logic [TOD_W-1:0] tod_held_bits;
  logic [YMD_W-1:0] ymd_held_bits;
  logic [1:0] sel;

  assign sel    = 2'(bus_addr);
  assign t_take = bus_wr && (sel == A_TOD);
  assign d_take = bus_wr && (sel == A_YMD);

  cal_commit_slot #(.W(TOD_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_tod_slot (
    .clk(clk), .rst(rst), .take(t_take), .din(TOD_W'(word_to_tod(bus_wdata))),
    .busy(t_busy), .fire(t_fire), .held(tod_held_bits)
  );

  cal_commit_slot #(.W(YMD_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_ymd_slot (
    .clk(clk), .rst(rst), .take(d_take), .din(YMD_W'(word_to_ymd(bus_wdata))),
    .busy(d_busy), .fire(d_fire), .held(ymd_held_bits)
  );

  assign tod_held = tod_t'(tod_held_bits);
  assign ymd_held = ymd_t'(ymd_held_bits);

  cal_tod_chain u_tod_chain (
    .cur(tod_q), .step(tick), .nxt(tod_nxt), .day_carry(day_carry)
  );

  cal_ymd_chain u_ymd_chain (
    .cur(ymd_q), .step(day_carry && !t_fire), .nxt(ymd_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q <= '0;
      ymd_q <= YMD_RESET;
    end else begin
      tod_q <= t_fire ? tod_held : tod_nxt;
      ymd_q <= d_fire ? ymd_held : ymd_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (sel)
        A_CTRL: begin
          bus_rdata[BUSY_TOD_BIT] <= t_busy;
          bus_rdata[BUSY_YMD_BIT] <= d_busy;
        end
        A_TOD:   bus_rdata <= tod_to_word(tod_q);
        A_YMD:   bus_rdata <= ymd_to_word(ymd_q);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cal_keeper_chk.sv
module cal_keeper_chk
  import cal_pkg::*;
#(
  parameter int COMMIT_CYCLES = 3,
  parameter int ADDR_W        = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic              t_busy,
  input logic              t_fire,
  input logic              d_fire,
  input tod_t              tod_q,
  input ymd_t              ymd_q
);
  localparam int RUN_W = $clog2(COMMIT_CYCLES + 2) + 1;
  logic [RUN_W-1:0] t_run;

  always_ff @(posedge clk) begin
    if (rst) t_run <= '0;
    else if (t_busy) t_run <= t_run + 1'b1;
    else t_run <= '0;
  end

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:23] == '0);

  p_busy_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(t_busy) |-> $past(bus_wr && (2'(bus_addr) == A_TOD)));

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    t_run <= RUN_W'(COMMIT_CYCLES));

  p_busy_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (t_busy && !t_fire && bus_wr) |=> t_busy);

  p_sec_step_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !t_fire && tod_q.sc < SEC_TOP) |=> tod_q.sc == $past(tod_q.sc) + 1'b1);

  p_tod_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !t_fire) |=> tod_q == $past(tod_q));

  p_ymd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !d_fire) |=> ymd_q == $past(ymd_q));
endmodule

bind cal_keeper cal_keeper_chk #(.COMMIT_CYCLES(COMMIT_CYCLES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .t_busy(t_busy), .t_fire(t_fire), .d_fire(d_fire),
  .tod_q(tod_q), .ymd_q(ymd_q)
);

// File: tb/test_cal_keeper.sv
module test_cal_keeper;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 0;
  bit done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  cal_keeper #(.COMMIT_CYCLES(N), .ADDR_W(2)) i_cal_keeper (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int ts, tm, th, dd, dm, dy, dl;
  int tcnt, dcnt;
  logic [31:0] tpend, dpend, exp_rdata;

  function automatic logic [31:0] tw(int h, int m, int s);
    return 32'(s) | (32'(m) << 8) | (32'(h) << 16);
  endfunction

  function automatic logic [31:0] dw(int l, int y, int mo, int d);
    return 32'(d) | (32'(mo) << 8) | (32'(y) << 16) | (32'(l) << 22);
  endfunction

  function automatic int mlen(int mo, int l);
    if (mo == 2) return (l != 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ts = 0; tm = 0; th = 0; dd = 1; dm = 1; dy = 0; dl = 0;
      tcnt = 0; dcnt = 0; tpend = 0; dpend = 0; exp_rdata = 0;
    end else begin
      int carry;
      bit tc, dc;
      case (bus_addr)
        2'd0: exp_rdata = ((tcnt != 0) ? 32'h100 : 32'h0) | ((dcnt != 0) ? 32'h80 : 32'h0);
        2'd1: exp_rdata = tw(th, tm, ts);
        2'd2: exp_rdata = dw(dl, dy, dm, dd);
        default: exp_rdata = 0;
      endcase
      tc = (tcnt == 1);
      dc = (dcnt == 1);
      carry = 0;
      if (tick) begin
        if (ts >= 59) begin
          ts = 0;
          if (tm >= 59) begin
            tm = 0;
            if (th >= 23) begin th = 0; carry = 1; end else th++;
          end else tm++;
        end else ts++;
      end
      if (tc) begin
        ts = int'(tpend[5:0]); tm = int'(tpend[13:8]); th = int'(tpend[20:16]);
        carry = 0;
      end
      if (carry != 0) begin
        if (dd >= mlen(dm, dl)) begin
          dd = 1;
          if (dm >= 12) begin
            dm = 1;
            dy = (dy + 1) % 64;
            dl = (((dy + 1970) % 4) == 0) ? 1 : 0;
          end else dm++;
        end else dd++;
      end
      if (dc) begin
        dd = int'(dpend[4:0]); dm = int'(dpend[11:8]); dy = int'(dpend[21:16]); dl = int'(dpend[22]);
      end
      if (bus_wr && bus_addr == 2'd1 && tcnt == 0) begin tcnt = N; tpend = bus_wdata & 32'h001F3F3F; end
      else if (tcnt != 0) tcnt--;
      if (bus_wr && bus_addr == 2'd2 && dcnt == 0) begin dcnt = N; dpend = bus_wdata & 32'h007F0F1F; end
      else if (dcnt != 0) dcnt--;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_chk++;
      if (bus_rdata !== exp_rdata) begin
        n_fail++;
        $display("FAIL %s model compare: got %h expected %h", phase, bus_rdata, exp_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input logic [1:0] a, input logic w, input logic [31:0] d, input logic t);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; tick = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(2'd0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] expv, input string req);
    step(a, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    n_chk++;
    if (bus_rdata !== expv) begin
      n_fail++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, bus_rdata, expv);
    end
  endtask

  task automatic set_all(input logic [31:0] t, input logic [31:0] d);
    step(2'd1, 1'b1, t, 1'b0);
    idle(N);
    step(2'd2, 1'b1, d, 1'b0);
    idle(N);
  endtask

  task automatic one_tick();
    step(2'd0, 1'b0, 32'h0, 1'b1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;

    phase = "R1";
    rd(2'd0, 32'h0, "R1");
    rd(2'd1, 32'h0, "R1");
    rd(2'd2, 32'h00000101, "R1");

    // R3: busy timing of a time write
    phase = "R3";
    step(2'd1, 1'b1, tw(23, 59, 58), 1'b0);
    rd(2'd0, 32'h100, "R3");
    step(2'd1, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    n_chk++;
    if (bus_rdata !== 32'h0) begin n_fail++; $display("FAIL R3 old time during busy: got %h expected %h", bus_rdata, 32'h0); end
    @(negedge clk);
    n_chk++;
    if (bus_rdata !== tw(23, 59, 58)) begin n_fail++; $display("FAIL R3 new time after commit: got %h expected %h", bus_rdata, tw(23, 59, 58)); end
    rd(2'd0, 32'h0, "R3");
    step(2'd2, 1'b1, dw(0, 0, 12, 31), 1'b0);
    rd(2'd0, 32'h80, "R3");
    idle(N);
    rd(2'd2, dw(0, 0, 12, 31), "R3");

    // R5/R7: day, month and year carry into 1971
    phase = "R5";
    one_tick();
    rd(2'd1, tw(23, 59, 59), "R5");
    one_tick();
    rd(2'd1, 32'h0, "R5");
    rd(2'd2, dw(0, 1, 1, 1), "R7");

    set_all(tw(10, 59, 59), dw(0, 1, 6, 10));
    one_tick();
    rd(2'd1, tw(11, 0, 0), "R5");
    set_all(tw(5, 20, 59), dw(0, 1, 6, 10));
    one_tick();
    rd(2'd1, tw(5, 21, 0), "R5");

    // R6: month lengths
    phase = "R6";
    set_all(tw(23, 59, 59), dw(1, 2, 2, 28));
    one_tick();
    rd(2'd2, dw(1, 2, 2, 29), "R6");
    set_all(tw(23, 59, 59), dw(1, 2, 2, 29));
    one_tick();
    rd(2'd2, dw(1, 2, 3, 1), "R6");
    set_all(tw(23, 59, 59), dw(0, 1, 2, 28));
    one_tick();
    rd(2'd2, dw(0, 1, 3, 1), "R6");
    set_all(tw(23, 59, 59), dw(0, 1, 4, 30));
    one_tick();
    rd(2'd2, dw(0, 1, 5, 1), "R6");
    set_all(tw(23, 59, 59), dw(0, 1, 1, 30));
    one_tick();
    rd(2'd2, dw(0, 1, 1, 31), "R6");

    // R7: entering a leap year
    phase = "R7";
    set_all(tw(23, 59, 59), dw(0, 1, 12, 31));
    one_tick();
    rd(2'd2, dw(1, 2, 1, 1), "R7");

    // R8: year wrap
    phase = "R8";
    set_all(tw(23, 59, 59), dw(0, 63, 12, 31));
    one_tick();
    rd(2'd2, dw(0, 0, 1, 1), "R8");

    // R4: second write while busy is dropped
    phase = "R4";
    step(2'd1, 1'b1, tw(7, 7, 7), 1'b0);
    step(2'd1, 1'b1, tw(9, 9, 9), 1'b0);
    idle(N);
    rd(2'd1, tw(7, 7, 7), "R4");
    step(2'd2, 1'b1, dw(0, 5, 5, 5), 1'b0);
    step(2'd2, 1'b1, dw(0, 9, 9, 9), 1'b0);
    idle(N);
    rd(2'd2, dw(0, 5, 5, 5), "R4");

    // R2: masking of written words
    phase = "R2";
    set_all(32'hFFC0C0C0 | tw(12, 34, 56), 32'hFF80F0E0 | dw(1, 9, 3, 4));
    rd(2'd1, tw(12, 34, 56), "R2");
    rd(2'd2, dw(1, 9, 3, 4), "R2");

    // R10: writes to control and unused address ignored
    phase = "R10";
    step(2'd0, 1'b1, 32'hFFFFFFFF, 1'b0);
    step(2'd3, 1'b1, 32'hFFFFFFFF, 1'b0);
    rd(2'd0, 32'h0, "R10");
    rd(2'd3, 32'h0, "R10");
    rd(2'd1, tw(12, 34, 56), "R10");
    rd(2'd2, dw(1, 9, 3, 4), "R10");

    // R9: no tick, values hold
    phase = "R9";
    idle(20);
    rd(2'd1, tw(12, 34, 56), "R9");
    rd(2'd2, dw(1, 9, 3, 4), "R9");

    // R11: commit wins over coincident tick and drops its carry
    phase = "R11";
    set_all(tw(23, 59, 59), dw(0, 3, 7, 15));
    step(2'd1, 1'b1, tw(4, 0, 0), 1'b0);
    idle(N - 1);
    one_tick();
    rd(2'd1, tw(4, 0, 0), "R11");
    rd(2'd2, dw(0, 3, 7, 15), "R11");
    step(2'd1, 1'b1, tw(1, 2, 3), 1'b1);
    for (int i = 0; i < N; i++) one_tick();
    rd(2'd1, tw(1, 2, 3), "R11");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule